// File: doc/BRIEF.md
# Floating-Point Min/Max Selection Unit

This block picks, or builds, the larger or smaller of two IEEE-754 operands. It offers four selections: largest by value, smallest by value, largest by magnitude and smallest by magnitude. Each works on 32-bit single or 64-bit double operands, chosen per request by a format bit. No arithmetic is done, so there is no rounding. The result is always one of the inputs, a quieted copy of a signalling NaN input, or a zero or infinity whose sign follows a fixed AND/OR rule.

A request is one cycle with `in_valid` high and the operands `fs` and `ft`, the operation code `op` and the format bit `is_double`. The answer appears on `result` on the next cycle with `out_valid` high. `invalid` is raised alongside when a signalling NaN was seen. A new request may be issued every cycle.

Top module: `fp_minmax_unit`

## Requirements
- R1: While reset is asserted, and until the first request completes, `out_valid`, `invalid` and `result` are all zero.
- R2: A request accepted on a clock edge with `in_valid` high gives `out_valid` high and its answer on the next edge. With `in_valid` low, `out_valid` and `invalid` are low one edge later. `op` is encoded as 00 largest-by-value, 01 smallest-by-value, 10 largest-by-magnitude and 11 smallest-by-magnitude. Back-to-back requests each produce a result.
- R3: When both operands are zeros of any sign, the value selections and magnitude selections return a zero. For the two "largest" operations its sign is the AND of the input signs; for the two "smallest" operations it is the OR.
- R4: When both operands are quiet NaNs (all-ones exponent, top mantissa bit set), the result is `fs` bit for bit.
- R5: When exactly one operand is a quiet NaN and the other is zero, subnormal, normal or infinite, the result is the other operand.
- R6: A signalling NaN (all-ones exponent, top mantissa bit clear, nonzero mantissa) on either input raises `invalid`. The result is that NaN with its top mantissa bit set. `fs` takes priority when both are signalling, and a signalling NaN outranks a quiet NaN on the other side. Without a signalling NaN, `invalid` is low.
- R7: The value selections order numbers by real value. Any positive number is above any negative one. Between two negative numbers, the one with the smaller magnitude is larger, for example largest(-5.0, -7.0) = -5.0.
- R8: For the magnitude selections with both operands infinite, the result is an infinity. Largest-by-magnitude gives it the AND of the signs; smallest-by-magnitude gives the OR.
- R9: For the magnitude selections with equal magnitudes and opposite signs, largest-by-magnitude returns the positive operand and smallest-by-magnitude returns the negative one.
- R10: For smallest-by-magnitude, a zero paired with a subnormal, normal or infinite operand yields the zero, and an infinity paired with a finite nonzero operand yields the finite one. Largest-by-magnitude yields the other operand in both cases.
- R11: Magnitudes are compared as the unsigned concatenation of exponent and mantissa fields, so subnormals order correctly against each other and against normals.
- R12: With `is_double` low, only bits 31:0 of `fs` and `ft` are used, with an 8-bit exponent and a 23-bit mantissa. Bits 63:32 have no effect, and `result[63:32]` is zero. With `is_double` high, all 64 bits are used, with an 11-bit exponent and a 52-bit mantissa.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op | input | 2 | Selection code (see R2) |
| is_double | input | 1 | 1 = double format, 0 = single in low 32 bits |
| fs | input | 64 | First operand |
| ft | input | 64 | Second operand |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 64 | Selected or constructed value |
| invalid | output | 1 | A signalling NaN was an input |

## Verification
The hardest situations to reach from the ports are the ones where the ordering rule is decided by a tie: equal magnitudes with opposite signs, opposed zeros and opposed infinities. Random operands almost never produce these. The stimulus builds them directly as constant operand pairs, in both operand orders, so that a design which always favours `fs` or always favours `ft` gives a wrong answer in at least one order. Signalling NaNs are paired with quiet NaNs and with each other to exercise the priority chain. Single-format requests carry garbage in the upper halves to show that those bits are ignored.

// File: rtl/fpsel_pkg.sv
package fpsel_pkg;

   typedef enum logic [1:0] {
      OP_MAX  = 2'b00,
      OP_MIN  = 2'b01,
      OP_MAXA = 2'b10,
      OP_MINA = 2'b11
   } fpsel_op_e;

   typedef enum logic [2:0] {
      CL_ZERO = 3'd0,
      CL_SUB  = 3'd1,
      CL_NORM = 3'd2,
      CL_INF  = 3'd3,
      CL_QNAN = 3'd4,
      CL_SNAN = 3'd5
   } fpsel_cls_e;

   typedef enum logic [1:0] {
      PK_FS  = 2'd0,
      PK_FT  = 2'd1,
      PK_QFS = 2'd2,
      PK_QFT = 2'd3
   } fpsel_pick_e;

endpackage

// File: rtl/fpsel_classify.sv
module fpsel_classify
   import fpsel_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   localparam int W    = EXP_W + MAN_W + 1
) (
   input  logic [W-1:0] val,
   output fpsel_cls_e   cls,
   output logic         sign,
   output logic [W-2:0] mag,
   output logic [W-1:0] quiet
);

   logic [EXP_W-1:0] ex;
   logic [MAN_W-1:0] mn;

   assign ex    = val[W-2:MAN_W];
   assign mn    = val[MAN_W-1:0];
   assign sign  = val[W-1];
   assign mag   = val[W-2:0];
   // quieting sets the leading mantissa bit, payload is kept
   assign quiet = val | (W'(1) << (MAN_W - 1));

   always_comb begin
      if (ex == '0) begin
         cls = (mn == '0) ? CL_ZERO : CL_SUB;
      end else if (&ex) begin
         if (mn == '0)          cls = CL_INF;
         else if (mn[MAN_W-1])  cls = CL_QNAN;
         else                   cls = CL_SNAN;
      end else begin
         cls = CL_NORM;
      end
   end

endmodule

// File: rtl/fpsel_pick.sv
module fpsel_pick
   import fpsel_pkg::*;
#(
   parameter int MAG_W = 31
) (
   input  fpsel_op_e        op,
   input  fpsel_cls_e       fs_cls,
   input  fpsel_cls_e       ft_cls,
   input  logic             fs_sign,
   input  logic             ft_sign,
   input  logic [MAG_W-1:0] fs_mag,
   input  logic [MAG_W-1:0] ft_mag,
   output fpsel_pick_e      pick,
   output logic             raise_inv
);

   logic fs_snan, ft_snan, fs_qnan, ft_qnan;
   logic mag_gt, mag_lt;
   logic fs_over, ft_over;

   assign fs_snan = (fs_cls == CL_SNAN);
   assign ft_snan = (ft_cls == CL_SNAN);
   assign fs_qnan = (fs_cls == CL_QNAN);
   assign ft_qnan = (ft_cls == CL_QNAN);

   // unsigned exponent:mantissa compare orders subnormals without shifting
   assign mag_gt = (fs_mag > ft_mag);
   assign mag_lt = (fs_mag < ft_mag);

   // strict value order; opposed zeros and infinities fall on the sign path
   always_comb begin
      if (fs_sign != ft_sign) begin
         fs_over = ~fs_sign;
         ft_over = fs_sign;
      end else if (!fs_sign) begin
         fs_over = mag_gt;
         ft_over = mag_lt;
      end else begin
         fs_over = mag_lt;
         ft_over = mag_gt;
      end
   end

   always_comb begin
      raise_inv = fs_snan | ft_snan;
      pick      = PK_FS;
      if (fs_snan) begin
         pick = PK_QFS;
      end else if (ft_snan) begin
         pick = PK_QFT;
      end else if (fs_qnan) begin
         pick = ft_qnan ? PK_FS : PK_FT;
      end else if (ft_qnan) begin
         pick = PK_FS;
      end else begin
         case (op)
            OP_MAX:  pick = ft_over ? PK_FT : PK_FS;
            OP_MIN:  pick = fs_over ? PK_FT : PK_FS;
            // equal magnitude: positive wins (sign AND for zeros/infinities)
            OP_MAXA: pick = mag_gt ? PK_FS : (mag_lt ? PK_FT : (fs_sign ? PK_FT : PK_FS));
            // equal magnitude: negative wins (sign OR for zeros/infinities)
            OP_MINA: pick = mag_lt ? PK_FS : (mag_gt ? PK_FT : (fs_sign ? PK_FS : PK_FT));
            default: pick = PK_FS;
         endcase
      end
   end

endmodule

// File: rtl/fpsel_lane.sv
module fpsel_lane
   import fpsel_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   localparam int W    = EXP_W + MAN_W + 1
) (
   input  fpsel_op_e    op,
   input  logic [W-1:0] fs_w,
   input  logic [W-1:0] ft_w,
   output logic [W-1:0] res_w,
   output logic         inv_w
);

   fpsel_cls_e   fs_cls, ft_cls;
   logic         fs_sign, ft_sign;
   logic [W-2:0] fs_mag, ft_mag;
   logic [W-1:0] fs_q, ft_q;
   fpsel_pick_e  pick;

   fpsel_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_fs (
      .val(fs_w), .cls(fs_cls), .sign(fs_sign), .mag(fs_mag), .quiet(fs_q)
   );

   fpsel_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_ft (
      .val(ft_w), .cls(ft_cls), .sign(ft_sign), .mag(ft_mag), .quiet(ft_q)
   );

   fpsel_pick #(.MAG_W(W - 1)) u_pick (
      .op(op), .fs_cls(fs_cls), .ft_cls(ft_cls),
      .fs_sign(fs_sign), .ft_sign(ft_sign),
      .fs_mag(fs_mag), .ft_mag(ft_mag),
      .pick(pick), .raise_inv(inv_w)
   );

   always_comb begin
      case (pick)
         PK_FS:   res_w = fs_w;
         PK_FT:   res_w = ft_w;
         PK_QFS:  res_w = fs_q;
         PK_QFT:  res_w = ft_q;
         default: res_w = fs_w;
      endcase
   end

endmodule

// File: rtl/fp_minmax_unit.sv
module fp_minmax_unit
   import fpsel_pkg::*;
#(
   parameter int SP_EXP = 8,
   parameter int SP_MAN = 23,
   parameter int DP_EXP = 11,
   parameter int DP_MAN = 52,
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        op,
   input  logic              is_double,
   input  logic [DATA_W-1:0] fs,
   input  logic [DATA_W-1:0] ft,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              invalid
);

   localparam int SP_W    = SP_EXP + SP_MAN + 1;
   localparam int DP_W    = DP_EXP + DP_MAN + 1;
   localparam int N_LANES = 2;

   if (DP_W != DATA_W) begin : g_chk_dp
      $error("double format width must equal DATA_W");
   end
   if (SP_W >= DP_W) begin : g_chk_sp
      $error("single format must be narrower than double");
   end

   fpsel_op_e         op_e;
   logic [DATA_W-1:0] lane_res [N_LANES];
   logic              lane_inv [N_LANES];
   logic [DATA_W-1:0] nxt_res;
   logic              nxt_inv;

   assign op_e = fpsel_op_e'(op);

   // lane 0 = single, lane 1 = double
   for (genvar g = 0; g < N_LANES; g++) begin : g_lane
      localparam int LE = (g == 0) ? SP_EXP : DP_EXP;
      localparam int LM = (g == 0) ? SP_MAN : DP_MAN;
      localparam int LW = LE + LM + 1;
      logic [LW-1:0] w_res;
      logic          w_inv;

      fpsel_lane #(.EXP_W(LE), .MAN_W(LM)) u_lane (
         .op(op_e), .fs_w(fs[LW-1:0]), .ft_w(ft[LW-1:0]),
         .res_w(w_res), .inv_w(w_inv)
      );

      assign lane_res[g] = DATA_W'(w_res);
      assign lane_inv[g] = w_inv;
   end

   assign nxt_res = is_double ? lane_res[1] : lane_res[0];
   assign nxt_inv = is_double ? lane_inv[1] : lane_inv[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         invalid   <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         invalid   <= in_valid & nxt_inv;
         if (in_valid) result <= nxt_res;
      end
   end

endmodule

// File: rtl/fpsel_checker.sv
module fpsel_checker #(
   parameter int DP_EXP = 11,
   parameter int DP_MAN = 52,
   parameter int SP_W   = 32,
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              is_double,
   input logic [DATA_W-1:0] fs,
   input logic [DATA_W-1:0] ft,
   input logic              out_valid,
   input logic [DATA_W-1:0] result,
   input logic              invalid
);

   logic fs_nanx, ft_nanx, fs_q, ft_q, fs_s, ft_s;

   assign fs_nanx = (&fs[DATA_W-2:DP_MAN]) && (fs[DP_MAN-1:0] != '0);
   assign ft_nanx = (&ft[DATA_W-2:DP_MAN]) && (ft[DP_MAN-1:0] != '0);
   assign fs_q    = fs_nanx && fs[DP_MAN-1];
   assign ft_q    = ft_nanx && ft[DP_MAN-1];
   assign fs_s    = fs_nanx && !fs[DP_MAN-1];
   assign ft_s    = ft_nanx && !ft[DP_MAN-1];

   // R2: a request yields a strobe one edge later
   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R2: idle cycles leave no strobe and no flag
   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !invalid));

   // R12: single results carry zero upper bits
   a_r12_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !is_double) |=> (result[DATA_W-1:SP_W] == '0));

   // R6: the flag tracks signalling NaNs on double requests
   a_r6_flag_dp: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_double) |=> (invalid == $past(fs_s || ft_s)));

   // R4: two quiet NaNs return fs untouched
   a_r4_qnan_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_double && fs_q && ft_q) |=> (result == $past(fs)));

endmodule

bind fp_minmax_unit fpsel_checker #(
   .DP_EXP(DP_EXP), .DP_MAN(DP_MAN), .SP_W(SP_W), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .is_double(is_double),
   .fs(fs), .ft(ft), .out_valid(out_valid), .result(result), .invalid(invalid)
);

// File: tb/sim_fp_minmax_unit.sv
module sim_fp_minmax_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  op = 2'b00;
   logic        is_double = 1'b0;
   logic [63:0] fs = '0;
   logic [63:0] ft = '0;
   logic        out_valid;
   logic [63:0] result;
   logic        invalid;

   int n_checks = 0;
   int n_fail   = 0;
   bit mon_en   = 1'b0;
   bit finished = 1'b0;

   logic [63:0] q_res [$];
   logic        q_inv [$];
   string       q_tag [$];

   localparam logic [1:0] MX = 2'b00, MN = 2'b01, MXA = 2'b10, MNA = 2'b11;

   // single constants (zero-extended)
   localparam logic [63:0] SP0 = 64'h0, SPN0 = 64'h80000000;
   localparam logic [63:0] SP5 = 64'h40A00000, SPN5 = 64'hC0A00000, SPN7 = 64'hC0E00000;
   localparam logic [63:0] SP3 = 64'h40400000, SPN3 = 64'hC0400000, SP100 = 64'h42C80000;
   localparam logic [63:0] SPINF = 64'h7F800000, SPNINF = 64'hFF800000;
   localparam logic [63:0] SPQ1 = 64'h7FC00001, SPQ2 = 64'h7FC00002;
   localparam logic [63:0] SPS1 = 64'h7F800005, SPS1Q = 64'h7FC00005;
   localparam logic [63:0] SPS2 = 64'hFF800007, SPS2Q = 64'hFFC00007;
   localparam logic [63:0] SPSUB = 64'h00000010, SPNSUB2 = 64'h80000020;
   localparam logic [63:0] SPMIN_NORM = 64'h00800000;
   // double constants
   localparam logic [63:0] DP1 = 64'h3FF0000000000000, DPN1 = 64'hBFF0000000000000;
   localparam logic [63:0] DPN2 = 64'hC000000000000000, DP2 = 64'h4000000000000000;
   localparam logic [63:0] DPINF = 64'h7FF0000000000000, DPNINF = 64'hFFF0000000000000;
   localparam logic [63:0] DPQ1 = 64'h7FF8000000000001, DPQ2 = 64'hFFF8000000000002;
   localparam logic [63:0] DPS = 64'h7FF0000000000009, DPSQ = 64'h7FF8000000000009;
   localparam logic [63:0] DPN0 = 64'h8000000000000000;

   fp_minmax_unit u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .is_double(is_double),
      .fs(fs), .ft(ft), .out_valid(out_valid), .result(result), .invalid(invalid)
   );

   always #5 clk = ~clk;

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp_v);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
      end
   endtask

   task automatic send(input logic [1:0] o, input logic d, input logic [63:0] a,
                       input logic [63:0] b, input logic [63:0] er, input logic ei,
                       input string tag);
      @(negedge clk);
      in_valid = 1'b1; op = o; is_double = d; fs = a; ft = b;
      q_res.push_back(er); q_inv.push_back(ei); q_tag.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         fs = '0; ft = '0;
      end
   endtask

   // monitor: pops one expectation per strobe
   always @(negedge clk) begin
      if (mon_en && out_valid) begin
         if (q_res.size() == 0) begin
            check(1'b0, "R2 unexpected strobe", result, 64'h0);
         end else begin
            logic [63:0] er;
            logic        ei;
            string       tg;
            er = q_res.pop_front(); ei = q_inv.pop_front(); tg = q_tag.pop_front();
            check(result == er, tg, result, er);
            check(invalid == ei, {tg, " flag"}, {63'h0, invalid}, {63'h0, ei});
         end
      end
   end

   initial begin
      #200000;
      if (!finished) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check({out_valid, invalid} == 2'b00 && result == '0, "R1 reset state", result, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R1 idle after reset", {63'h0, out_valid}, 64'h0);
      mon_en = 1'b1;

      // R3 opposed and equal zeros
      send(MX,  0, SP0,  SPN0, SP0,  0, "R3 max +0,-0");
      send(MN,  0, SP0,  SPN0, SPN0, 0, "R3 min +0,-0");
      send(MXA, 0, SPN0, SP0,  SP0,  0, "R3 maxa -0,+0");
      send(MNA, 0, SPN0, SP0,  SPN0, 0, "R3 mina -0,+0");
      send(MX,  1, DPN0, DPN0, DPN0, 0, "R3 max -0,-0 dp");
      // R4 both quiet NaN
      send(MX,  0, SPQ1, SPQ2, SPQ1, 0, "R4 qnan pair sp");
      send(MNA, 1, DPQ2, DPQ1, DPQ2, 0, "R4 qnan pair dp");
      // R5 one quiet NaN
      send(MN,  0, SPQ1, SP5,    SP5,    0, "R5 qnan,num");
      send(MXA, 0, SPNINF, SPQ2, SPNINF, 0, "R5 inf,qnan");
      // R6 signalling NaNs
      send(MX,  0, SPS1, SP5,  SPS1Q, 1, "R6 snan fs");
      send(MN,  0, SP5,  SPS2, SPS2Q, 1, "R6 snan ft");
      send(MX,  0, SPQ1, SPS1, SPS1Q, 1, "R6 snan over qnan");
      send(MNA, 0, SPS1, SPS2, SPS1Q, 1, "R6 both snan fs wins");
      send(MXA, 1, DP1,  DPS,  DPSQ,  1, "R6 snan dp");
      // R7 value ordering
      send(MX,  0, SPN5, SPN7, SPN5, 0, "R7 max negatives");
      send(MX,  0, SPN7, SPN5, SPN5, 0, "R7 max negatives swapped");
      send(MN,  0, SPN5, SPN7, SPN7, 0, "R7 min negatives");
      send(MX,  0, SP3,  SP5,  SP5,  0, "R7 max positives");
      send(MN,  0, SP3,  SPN3, SPN3, 0, "R7 min mixed sign");
      send(MX,  1, DPN1, DPN2, DPN1, 0, "R7 max negatives dp");
      send(MN,  1, DPNINF, DPN2, DPNINF, 0, "R7 min -inf dp");
      // R8 magnitude with two infinities
      send(MXA, 0, SPINF,  SPNINF, SPINF,  0, "R8 maxa inf,-inf");
      send(MNA, 0, SPINF,  SPNINF, SPNINF, 0, "R8 mina inf,-inf");
      send(MXA, 1, DPNINF, DPINF,  DPINF,  0, "R8 maxa -inf,inf dp");
      send(MNA, 1, DPNINF, DPNINF, DPNINF, 0, "R8 mina -inf,-inf dp");
      // R9 magnitude ties
      send(MXA, 0, SPN3, SP3, SP3,  0, "R9 maxa -3,3");
      send(MXA, 0, SP3, SPN3, SP3,  0, "R9 maxa 3,-3");
      send(MNA, 0, SPN3, SP3, SPN3, 0, "R9 mina -3,3");
      send(MNA, 0, SP3, SPN3, SPN3, 0, "R9 mina 3,-3");
      send(MNA, 1, DP2, DPN2, DPN2, 0, "R9 mina dp");
      // R10 zero and infinity against finite
      send(MNA, 0, SP100, SP0,  SP0,   0, "R10 mina 100,0");
      send(MXA, 0, SP100, SP0,  SP100, 0, "R10 maxa 100,0");
      send(MNA, 0, SPINF, SPN5, SPN5,  0, "R10 mina inf,-5");
      send(MXA, 0, SPINF, SPN5, SPINF, 0, "R10 maxa inf,-5");
      send(MNA, 0, SPN0,  SPINF, SPN0, 0, "R10 mina -0,inf");
      send(MNA, 0, SP0,   SPSUB, SP0,  0, "R10 mina 0,sub");
      // R11 subnormal magnitudes
      send(MXA, 0, SPSUB, SPNSUB2, SPNSUB2, 0, "R11 maxa subnormals");
      send(MNA, 0, SPMIN_NORM, SPSUB, SPSUB, 0, "R11 mina norm,sub");
      send(MX,  0, SPNSUB2, SPSUB, SPSUB, 0, "R11 max signed subnormals");
      // R12 upper bits ignored in single mode
      send(MX,  0, 64'hFFFFFFFF_40A00000, 64'h12345678_40400000, SP5, 0, "R12 upper ignored max");
      send(MNA, 0, 64'hDEADBEEF_C0400000, 64'h00000001_40A00000, SPN3, 0, "R12 upper ignored mina");
      send(MX,  0, 64'h7FF00000_00000000, 64'h7FF00000_00000001, 64'h1, 0, "R12 upper nan ignored");
      idle(2);
      check(out_valid == 1'b0 && invalid == 1'b0, "R2 idle no strobe",
            {62'h0, out_valid, invalid}, 64'h0);
      // R2 single gap then one request
      send(MN, 1, DP1, DPN1, DPN1, 0, "R2 after gap");
      idle(3);
      check(q_res.size() == 0, "R2 all results returned", 64'(q_res.size()), 64'h0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule